// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the bus-side state machine of a 16-bit processor whose low address bits and data bits share one set of pins. The core hands it a single transfer request: direction, memory or I/O space, byte or word size, a 20-bit address and write data. The sequencer then runs one bus cycle of four T states (T1 to T4). Each T state lasts `PHASES` clocks. The cycle is stretched by wait states (Tw) while the responding device holds `ready` low.

In T1 the sequencer pulses `ale` and drives the address onto the shared lines, so that an external latch can hold the address on the falling edge of `ale`. From T2 on, the shared lines carry data. On a read they float, and the read strobe is delayed to the second half of T2. On a write, the write strobe and the data both start at the beginning of T2. The sequencer also drives the transceiver enable and the transceiver direction, and sequences the two so that the transceivers never reverse while they are enabled. A word request at an odd address is split into two byte cycles. A read finishes with the assembled word on `rdata` and a one-clock `done` pulse.

The shared lines appear as a separate output, output-enable and input (`ad_out`, `ad_oe`, `ad_in`). The tri-state pad is built outside the block.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset `busy`, `done`, `ale` and `ad_oe` are 0, and `rd_n`, `wr_n` and `den_n` are 1. A request is accepted when `req_valid` is 1 while `busy` is 0. Each part of a transfer then occupies 4·PHASES + PHASES·(number of wait states) clocks with `busy` at 1. `done` is 1 for exactly the one clock after the final T4.
- R2: `ale` is 1 for the first PHASES/2 clocks of T1. During T1, `ad_out` carries address bits 15:0, `ad_oe` is 1 and `a_hi` carries address bits 19:16.
- R3: `mem_io` (1 = memory, 0 = I/O) and `dtr` (1 = processor to bus, 0 = bus to processor) take the request's values at the start of the cycle. Both hold steady while `busy` stays 1. `dtr` changes only after `den_n` has been 1 for at least one clock.
- R4: The byte-enable pair is `bhe_n` together with address bit 0, which is `ad_out[0]` during T1. The encodings are: (0,0) for a word, (1,0) for an even byte on `ad[7:0]`, and (0,1) for an odd byte on `ad[15:8]`.
- R5: On a read, `ad_oe` is 0 from T2 onward. `rd_n` falls only at the start of the second half of T2 (clock index 3 after the T1 start with PHASES=2) and is never 0 while `ad_oe` is 1.
- R6: On a write, `wr_n` falls at the start of T2 (clock index 2). The write data is driven on `ad_out` from T2 until the middle of T4. A byte is driven on both lanes, and the device takes it from the lane that the R4 encoding selects.
- R7: `ready` is sampled on the last clock of T3 and of each Tw. Each sample at 0 adds one Tw of PHASES clocks. During Tw, every bus control output holds its value.
- R8: Read data is captured from `ad_in` on the edge that ends the last T3/Tw. A word read returns `{ad_in[15:8], ad_in[7:0]}`. A byte read returns the selected lane in `rdata[7:0]` with `rdata[15:8]` = 0.
- R9: A word request at an odd address runs two byte cycles back to back with no idle clock between them. The first cycle uses the address itself, encoding (0,1), and carries data bits 7:0 on the high lane. The second uses the address plus 1 (modulo 2^20), encoding (1,0), and carries data bits 15:8 on the low lane.
- R10: `den_n` is 0 whenever `rd_n` or `wr_n` is 0. On a write it falls at the start of T2, and on a read together with `rd_n`. It returns to 1 at the middle of T4.
- R11: `rd_n` and `wr_n` are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request, taken while busy is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (a byte uses bits 7:0) |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read data |
| ad_out | output | 16 | Shared lines, value driven |
| ad_oe | output | 1 | Shared lines, drive enable |
| ad_in | input | 16 | Shared lines, value seen at the pads |
| a_hi | output | 4 | Address bits 19:16 |
| ale | output | 1 | Address latch strobe |
| mem_io | output | 1 | Space select |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dtr | output | 1 | Transceiver direction |
| bhe_n | output | 1 | High byte enable, active low |
| ready | input | 1 | Device ready, sampled at the end of T3/Tw |

## Verification
The assertions assume that `ready` is significant only on the last clock of T3 and Tw. They also assume that the request fields are sampled only on the accepting clock. The transceiver-direction and wait-hold properties therefore allow `ready` and the request inputs to move freely at any other time. The stimulus keeps the request fields stable until `busy` rises, and then drops `req_valid`. `ready` comes from a device model that counts clocks from the fall of `ale` and raises `ready` after a chosen number of wait states, from 0 to 3. Addresses, sizes, directions and wait counts are drawn at random with a fixed seed. Directed cases are added for odd word transfers, including the one at the top of the address space that wraps to zero.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5
   } bstate_t;

   typedef enum logic [1:0] {
      LN_LO   = 2'd0,
      LN_HI   = 2'd1,
      LN_BOTH = 2'd2
   } lane_t;
endpackage

// File: rtl/mbus_timer.sv
module mbus_timer
   import mbus_pkg::*;
#(
   parameter int PHASES = 2,
   localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ready,
   input  logic          more,
   output bstate_t       st,
   output logic [PW-1:0] ph,
   output logic          cap,
   output logic          t4_end
);
   localparam logic [PW-1:0] LAST_P = PW'(PHASES - 1);

   logic last;
   assign last   = (ph == LAST_P);
   assign cap    = ((st == ST_T3) || (st == ST_TW)) && last && ready;
   assign t4_end = (st == ST_T4) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         ph <= '0;
      end else if (st == ST_IDLE) begin
         ph <= '0;
         if (start) st <= ST_T1;
      end else if (!last) begin
         ph <= ph + PW'(1);
      end else begin
         ph <= '0;
         unique case (st)
            ST_T1:   st <= ST_T2;
            ST_T2:   st <= ST_T3;
            ST_T3,
            ST_TW:   st <= ready ? ST_T4 : ST_TW;
            ST_T4:   st <= more ? ST_T1 : ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R7: T4 is entered only after ready was seen high
   a_r7_t4_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_T4 && ph == '0) |-> $past(ready));

   // R1: phase counter stays inside one T state
   a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |-> (ph <= LAST_P));
endmodule

// File: rtl/mbus_lanes.sv
module mbus_lanes
   import mbus_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  lane_t             lane,
   input  logic              part2,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] ad_in,
   input  logic [DATA_W-1:0] rdata_cur,
   output logic [DATA_W-1:0] drive,
   output logic [DATA_W-1:0] rd_next
);
   localparam int BW = DATA_W / 2;

   logic [BW-1:0] wbyte;
   logic [BW-1:0] rbyte;

   assign wbyte = part2 ? wdata[DATA_W-1:BW] : wdata[BW-1:0];
   assign rbyte = (lane == LN_HI) ? ad_in[DATA_W-1:BW] : ad_in[BW-1:0];

   always_comb begin
      if (lane == LN_BOTH) begin
         drive   = wdata;
         rd_next = ad_in;
      end else begin
         drive = {wbyte, wbyte};
         if (part2) rd_next = {rbyte, rdata_cur[BW-1:0]};
         else       rd_next = {{BW{1'b0}}, rbyte};
      end
   end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbus_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int PHASES = 2,
   localparam int HI_W = ADDR_W - DATA_W,
   localparam int PW   = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_mem,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic [HI_W-1:0]   a_hi,
   output logic              ale,
   output logic              mem_io,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              dtr,
   output logic              bhe_n,
   input  logic              ready
);
   localparam logic [PW-1:0] MID_P = PW'(PHASES / 2);

   if (DATA_W != 16) begin : g_bad_width
      $error("mux_bus_seq: DATA_W must be 16 (two byte lanes)");
   end
   if (HI_W < 1) begin : g_bad_addr
      $error("mux_bus_seq: ADDR_W must exceed DATA_W");
   end
   if (PHASES < 2) begin : g_bad_phase
      $error("mux_bus_seq: PHASES must be at least 2");
   end

   bstate_t          st;
   logic [PW-1:0]    ph;
   logic             cap, t4_end, start, more;
   logic             wr_q, split_q, part2_q, done_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] wdata_q, rdata_q, drive, rd_next;
   lane_t            lane_q;

   assign start = (st == ST_IDLE) && req_valid;
   assign more  = split_q && !part2_q;

   mbus_timer #(.PHASES(PHASES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .more(more),
      .st(st), .ph(ph), .cap(cap), .t4_end(t4_end)
   );

   mbus_lanes #(.DATA_W(DATA_W)) u_lanes (
      .lane(lane_q), .part2(part2_q), .wdata(wdata_q), .ad_in(ad_in),
      .rdata_cur(rdata_q), .drive(drive), .rd_next(rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q     <= 1'b0;
         mem_io   <= 1'b0;
         dtr      <= 1'b0;
         split_q  <= 1'b0;
         part2_q  <= 1'b0;
         cur_addr <= '0;
         wdata_q  <= '0;
         lane_q   <= LN_BOTH;
      end else if (start) begin
         wr_q     <= req_write;
         mem_io   <= req_mem;
         dtr      <= req_write;
         split_q  <= req_word && req_addr[0];
         part2_q  <= 1'b0;
         cur_addr <= req_addr;
         wdata_q  <= req_wdata;
         if (req_addr[0])   lane_q <= LN_HI;
         else if (req_word) lane_q <= LN_BOTH;
         else               lane_q <= LN_LO;
      end else if (t4_end && more) begin
         part2_q  <= 1'b1;
         cur_addr <= cur_addr + ADDR_W'(1);
         lane_q   <= LN_LO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= t4_end && !more;
         if (cap && !wr_q) rdata_q <= rd_next;
      end
   end

   logic in_t1, mid_strobe, data_ph, den_win;
   assign in_t1      = (st == ST_T1);
   assign mid_strobe = (st == ST_T3) || (st == ST_TW);
   assign data_ph    = (st == ST_T2) || mid_strobe || ((st == ST_T4) && (ph < MID_P));
   assign den_win    = ((st == ST_T2) && (wr_q || ph >= MID_P)) || mid_strobe
                       || ((st == ST_T4) && (ph < MID_P));

   assign busy   = (st != ST_IDLE);
   assign done   = done_q;
   assign rdata  = rdata_q;
   assign ale    = in_t1 && (ph < MID_P);
   assign ad_oe  = in_t1 || (wr_q && data_ph);
   assign ad_out = in_t1 ? cur_addr[DATA_W-1:0] : drive;
   assign a_hi   = cur_addr[ADDR_W-1:DATA_W];
   assign bhe_n  = (lane_q == LN_LO);
   assign rd_n   = !(!wr_q && (((st == ST_T2) && (ph >= MID_P)) || mid_strobe));
   assign wr_n   = !(wr_q && ((st == ST_T2) || mid_strobe));
   assign den_n  = !(busy && den_win);

   // R11: strobes exclusive
   a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n || wr_n));

   // R5: read strobe never while the processor drives the lines
   a_r5_read_float: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   // R6: write strobe always has data on the lines
   a_r6_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> ad_oe);

   // R3: direction turns only with transceivers disabled for a full clock
   a_r3_dtr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dtr) |-> (den_n && $past(den_n)));

   // R3: space select held through the transfer
   a_r3_mio_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_io));

   // R7: controls frozen in wait states
   a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TW && $past(st == ST_TW)) |->
         $stable({rd_n, wr_n, den_n, ale, ad_oe, bhe_n}));

   // R2: address strobe only while the address is driven
   a_r2_ale_drives: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe && rd_n && wr_n));

   // R10: transceivers enabled whenever a strobe is active
   a_r10_den_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> !den_n);

   // R1: completion is a single-clock pulse
   a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/mux_bus_seq_test.sv
`timescale 1ns/1ps
module mux_bus_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done, ad_oe, ale, mem_io, rd_n, wr_n, den_n, dtr, bhe_n;
   logic [15:0] rdata, ad_out, ad_in;
   logic [3:0]  a_hi;
   logic        ready;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int waits = 0;

   always #10 clk = ~clk;

   mux_bus_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_mem(req_mem), .req_word(req_word), .req_addr(req_addr),
      .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
      .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .ale(ale),
      .mem_io(mem_io), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dtr(dtr),
      .bhe_n(bhe_n), .ready(ready)
   );

   // device model: address latch, byte-lane memory, ready generator
   logic [7:0]  mem     [0:1023];
   logic [7:0]  ref_mem [0:1023];
   logic [19:0] lat_addr = '0;
   logic        lat_bhe = 1'b1;

   always @(negedge ale) begin
      lat_addr <= {a_hi, ad_out};
      lat_bhe  <= bhe_n;
   end

   assign ad_in = !rd_n ? {mem[{lat_addr[9:1], 1'b1}], mem[{lat_addr[9:1], 1'b0}]}
                        : 16'hA5A5;

   always @(posedge wr_n) begin
      if (rst_n) begin
         if (!lat_bhe)     mem[{lat_addr[9:1], 1'b1}] <= ad_out[15:8];
         if (!lat_addr[0]) mem[{lat_addr[9:1], 1'b0}] <= ad_out[7:0];
      end
   end

   always @(posedge clk) begin
      if (ale) cyc <= 1;
      else     cyc <= cyc + 1;
   end
   assign ready = (cyc >= 5 + 2 * waits);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(input logic [19:0] a, input bit word);
      logic [9:0] i0 = a[9:0];
      logic [9:0] i1 = a[9:0] + 10'd1;
      return word ? {ref_mem[i1], ref_mem[i0]} : {8'h00, ref_mem[i0]};
   endfunction

   task automatic do_op(input bit w, input bit m, input bit wd,
                        input logic [19:0] a, input logic [15:0] d, input int nw);
      int n = 0, parts = 0, guard = 0;
      int first_rd = -1, first_wr = -1, first_den = -1;
      logic [19:0] la [2];
      logic [1:0]  enc [2];
      bit split = wd && a[0];
      int exp_parts = split ? 2 : 1;
      logic [19:0] a1 = a + 20'd1;
      waits     = nw;
      req_write = w; req_mem = m; req_word = wd; req_addr = a; req_wdata = d;
      req_valid = 1'b1;
      forever begin
         @(negedge clk);
         guard++;
         if (busy) begin
            req_valid = 1'b0;
            n++;
         end
         if (ale && parts < 2) begin
            la[parts]  = {a_hi, ad_out};
            enc[parts] = {bhe_n, ad_out[0]};
            chk("R2 ad_oe with ale", {31'd0, ad_oe}, 32'd1);
            chk("R3 dtr at T1", {31'd0, dtr}, {31'd0, w});
            chk("R3 mem_io at T1", {31'd0, mem_io}, {31'd0, m});
            parts++;
         end
         if (parts == 1) begin
            if (!rd_n && first_rd < 0) first_rd = cyc;
            if (!wr_n && first_wr < 0) first_wr = cyc;
            if (!den_n && first_den < 0) first_den = cyc;
         end
         if (done || guard > 200) break;
      end
      chk("R1 done seen", {31'd0, done}, 32'd1);
      chk("R9 part count", parts, exp_parts);
      chk("R1/R7 busy clocks", n, exp_parts * (8 + 2 * nw));
      chk("R2 latched address", {12'd0, la[0]}, {12'd0, a});
      if (split) begin
         chk("R9 first part encoding", enc[0], 2'b01);
         chk("R9 second part address", {12'd0, la[1]}, {12'd0, a1});
         chk("R9 second part encoding", enc[1], 2'b10);
      end else if (wd) begin
         chk("R4 word encoding", enc[0], 2'b00);
      end else begin
         chk("R4 byte encoding", enc[0], a[0] ? 2'b01 : 2'b10);
      end
      if (w) begin
         chk("R6 wr_n fall index", first_wr, 2);
         chk("R10 den_n fall write", first_den, 2);
         chk("R11 no read strobe on write", first_rd, -1);
         ref_mem[a[9:0]] = d[7:0];
         if (wd) ref_mem[a1[9:0]] = d[15:8];
         chk("R6 stored low", mem[a[9:0]], ref_mem[a[9:0]]);
         if (wd) chk("R6/R9 stored high", mem[a1[9:0]], ref_mem[a1[9:0]]);
      end else begin
         chk("R5 rd_n fall index", first_rd, 3);
         chk("R10 den_n fall read", first_den, 3);
         chk("R11 no write strobe on read", first_wr, -1);
         chk("R8 read data", rdata, exp_read(a, wd));
      end
      @(negedge clk);
      chk("R1 done one clock", {31'd0, done}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      for (int i = 0; i < 1024; i++) begin
         mem[i]     = 8'(i * 37 + 11);
         ref_mem[i] = 8'(i * 37 + 11);
      end
      repeat (3) @(negedge clk);
      chk("R1 reset busy", {31'd0, busy}, 32'd0);
      chk("R1 reset done", {31'd0, done}, 32'd0);
      chk("R1 reset strobes", {29'd0, rd_n, wr_n, den_n}, 32'd7);
      chk("R1 reset ale/oe", {30'd0, ale, ad_oe}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      do_op(1, 1, 1, 20'h12344, 16'hBEEF, 0);
      do_op(0, 1, 1, 20'h12344, 16'h0000, 0);
      do_op(1, 1, 1, 20'h00101, 16'h1234, 2);
      do_op(0, 1, 1, 20'h00101, 16'h0000, 1);
      do_op(1, 0, 0, 20'h00200, 16'h775A, 0);
      do_op(1, 1, 0, 20'h00201, 16'h33C3, 3);
      do_op(0, 1, 1, 20'h00200, 16'h0000, 0);
      do_op(0, 0, 0, 20'h00201, 16'h0000, 2);
      do_op(0, 1, 0, 20'h00200, 16'h0000, 0);
      do_op(1, 1, 1, 20'hFFFFF, 16'hA1B2, 1);
      do_op(0, 1, 1, 20'hFFFFF, 16'h0000, 0);

      for (int k = 0; k < 60; k++) begin
         do_op(1'($urandom), 1'($urandom), 1'($urandom), 20'($urandom),
               16'($urandom), int'($urandom % 4));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
   end
endmodule